// File: doc/BRIEF.md
# Cross-VP Ring Transfer Queue

This block passes single operands between neighbouring virtual processors that are spread round-robin over a set of lanes. A VP that names its successor as a destination presents the value on its lane's send port. The value lands in a one-entry link buffer that feeds the lane holding the next VP slot. The last lane's link returns to lane 0, where the next group of VP slots sits. A receive waits until the value is present, so sender and receiver synchronise through valid/ready and need no fixed schedule.

A send marked as coming from the highest-numbered active VP does not go to a neighbour. It enters a small wrap-around FIFO instead. Lane 0 drains that FIFO when it is receiving on behalf of VP 0. The control processor has its own push and pop ports on the same FIFO. It can seed a loop-carried chain before a broadcast fetch and collect the final value afterwards. The FIFO never drops or duplicates data. A full FIFO refuses writes and an empty one offers nothing.

Top module: `xvp_ring_xfer`

## Requirements
- R1: During reset and in the first cycle after it, every `rx_valid` bit and `cp_pop_valid` are 0, while `cp_push_ready` and every `tx_ready` bit are 1.
- R2: A send on lane k with `tx_last`=0 that is accepted at a clock edge is visible on lane (k+1) mod NLANES after that edge, with the same data. For k = NLANES-1 the receiving lane is lane 0, and there `rx_first` must be 0.
- R3: Each link holds one value. While it is full and its receiver does not take it, the sender's `tx_ready` is 0 and the receiver's data stays stable. When the receiver takes the value, a new send is accepted in that same cycle.
- R4: A send with `tx_last`=1 is written into the wrap-around FIFO. Lane 0 with `rx_first`=1 reads those values in arrival order.
- R5: Values pushed by the control processor leave through `cp_pop_data` in push order.
- R6: After QDEPTH writes with no reads, `cp_push_ready` is 0 and a further push is not stored. When the FIFO is empty, `cp_pop_valid` is 0.
- R7: In any cycle with a valid `tx_last` send, `cp_push_ready` is 0. The VP value is written first, and the control processor's value follows it.
- R8: While `rx_first` is 1, `cp_pop_valid` is 0 and lane 0 sees the head of the FIFO on `rx_valid[0]`/`rx_data`.
- R9: While `rx_first` is 0, lane 0 receives from the link of lane NLANES-1.
- R10: A push and a pop in the same cycle both take effect. The FIFO keeps every value in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | NLANES | Per-lane send request |
| tx_last | input | NLANES | Send comes from the highest active VP (goes to the FIFO) |
| tx_data | input | NLANES*W | Per-lane send data, lane k in bits [k*W +: W] |
| tx_ready | output | NLANES | Per-lane send accepted |
| rx_valid | output | NLANES | Per-lane received value present |
| rx_data | output | NLANES*W | Per-lane received data |
| rx_ready | input | NLANES | Per-lane receive consumes the value |
| rx_first | input | 1 | Lane 0 receives for VP 0 (from the FIFO) |
| cp_push_valid | input | 1 | Control processor push request |
| cp_push_data | input | W | Control processor push data |
| cp_push_ready | output | 1 | Push accepted |
| cp_pop_valid | output | 1 | FIFO head available to the control processor |
| cp_pop_data | output | W | FIFO head data |
| cp_pop_ready | input | 1 | Control processor pop |

## Verification
Two writes can reach the wrap-around FIFO in one cycle: a send marked last and a control-processor push. The bench raises both on the same edge. It judges the outcome by `cp_push_ready` going low in that cycle and by the pop order afterwards, where the VP value comes out ahead of the pushed one. The read side has a matching case, where a push and a pop land on the same edge. The bench checks that neither is lost by draining the FIFO and comparing every value and the final empty state.

// File: rtl/xvp_ring_pkg.sv
package xvp_ring_pkg;
  // Lane that holds the successor slot of a VP living in lane k.
  function automatic int unsigned ring_next(input int unsigned k, input int unsigned n);
    return (k + 1) % n;
  endfunction
endpackage

// File: rtl/xvp_ring_link.sv
module xvp_ring_link #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) data_q <= in_data;
  end
endmodule

// File: rtl/xvp_wrap_fifo.sv
module xvp_wrap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= bump(wptr_q);
      if (do_rd) rptr_q <= bump(rptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/xvp_ring_xfer.sv
module xvp_ring_xfer #(
  parameter int NLANES = 4,
  parameter int W      = 16,
  parameter int QDEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NLANES-1:0]   tx_valid,
  input  logic [NLANES-1:0]   tx_last,
  input  logic [NLANES*W-1:0] tx_data,
  output logic [NLANES-1:0]   tx_ready,
  output logic [NLANES-1:0]   rx_valid,
  output logic [NLANES*W-1:0] rx_data,
  input  logic [NLANES-1:0]   rx_ready,
  input  logic                rx_first,
  input  logic                cp_push_valid,
  input  logic [W-1:0]        cp_push_data,
  output logic                cp_push_ready,
  output logic                cp_pop_valid,
  output logic [W-1:0]        cp_pop_data,
  input  logic                cp_pop_ready
);
  import xvp_ring_pkg::*;

  logic [NLANES-1:0] lk_in_valid, lk_in_ready, lk_out_valid, lk_out_ready;
  logic [W-1:0]      lk_out_data [NLANES];

  logic         q_wr_en, q_rd_en, q_full, q_empty, vp_wr;
  logic [W-1:0] q_wr_data, q_rd_data, vp_wr_data;

  // Per-lane link toward the successor lane
  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    localparam int unsigned DST = ring_next(k, NLANES);

    assign lk_in_valid[k] = tx_valid[k] && !tx_last[k];
    assign tx_ready[k]    = tx_last[k] ? !q_full : lk_in_ready[k];

    xvp_ring_link #(.W(W)) u_link (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (lk_in_valid[k]),
      .in_data   (tx_data[k*W +: W]),
      .in_ready  (lk_in_ready[k]),
      .out_valid (lk_out_valid[k]),
      .out_data  (lk_out_data[k]),
      .out_ready (lk_out_ready[k])
    );

    if (DST == 0) begin : g_wrap_dst
      assign lk_out_ready[k] = rx_ready[0] && !rx_first;
    end else begin : g_plain_dst
      assign lk_out_ready[k]     = rx_ready[DST];
      assign rx_valid[DST]       = lk_out_valid[k];
      assign rx_data[DST*W +: W] = lk_out_data[k];
    end
  end

  // Lane 0 picks the FIFO head for VP 0, otherwise the last lane's link
  assign rx_valid[0]  = rx_first ? !q_empty : lk_out_valid[NLANES-1];
  assign rx_data[W-1:0] = rx_first ? q_rd_data : lk_out_data[NLANES-1];

  // Write side: a VP send marked last beats the control processor
  always_comb begin
    vp_wr      = 1'b0;
    vp_wr_data = '0;
    for (int k = 0; k < NLANES; k++) begin
      if (tx_valid[k] && tx_last[k]) begin
        vp_wr      = 1'b1;
        vp_wr_data = tx_data[k*W +: W];
      end
    end
  end

  assign cp_push_ready = !q_full && !vp_wr;
  assign q_wr_en       = vp_wr || cp_push_valid;
  assign q_wr_data     = vp_wr ? vp_wr_data : cp_push_data;

  // Read side: lane 0 owns the head while it receives for VP 0
  assign cp_pop_valid = !q_empty && !rx_first;
  assign cp_pop_data  = q_rd_data;
  assign q_rd_en      = rx_first ? rx_ready[0] : cp_pop_ready;

  xvp_wrap_fifo #(.W(W), .DEPTH(QDEPTH)) u_wrapq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (q_wr_en),
    .wr_data (q_wr_data),
    .rd_en   (q_rd_en),
    .rd_data (q_rd_data),
    .full    (q_full),
    .empty   (q_empty)
  );
endmodule

// File: rtl/xvp_ring_xfer_chk.sv
module xvp_ring_xfer_chk #(
  parameter int NLANES = 4,
  parameter int W      = 16,
  parameter int QDEPTH = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NLANES-1:0]   tx_valid,
  input logic [NLANES-1:0]   tx_last,
  input logic [NLANES*W-1:0] tx_data,
  input logic [NLANES-1:0]   tx_ready,
  input logic [NLANES-1:0]   rx_valid,
  input logic [NLANES*W-1:0] rx_data,
  input logic [NLANES-1:0]   rx_ready,
  input logic                rx_first,
  input logic                cp_push_valid,
  input logic [W-1:0]        cp_push_data,
  input logic                cp_push_ready,
  input logic                cp_pop_valid,
  input logic [W-1:0]        cp_pop_data,
  input logic                cp_pop_ready
);
  localparam int CW = $clog2(QDEPTH + 1) + 1;

  logic [CW-1:0] occ_q;
  logic          wr_fire, rd_fire;

  assign wr_fire = (|(tx_valid & tx_last & tx_ready)) || (cp_push_valid && cp_push_ready);
  assign rd_fire = (rx_first && rx_valid[0] && rx_ready[0]) || (cp_pop_valid && cp_pop_ready);

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= occ_q + CW'(wr_fire) - CW'(rd_fire);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (rx_valid == '0 && !cp_pop_valid)); // R1
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst) occ_q <= CW'(QDEPTH)); // R6
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst) (occ_q == CW'(QDEPTH)) |-> !cp_push_ready); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) (occ_q == '0) |-> !cp_pop_valid); // R6
  AST_VP_FIRST: assert property (@(posedge clk) disable iff (rst) (|(tx_valid & tx_last)) |-> !cp_push_ready); // R7
  AST_LANE0_OWNS: assert property (@(posedge clk) disable iff (rst) rx_first |-> !cp_pop_valid); // R8
  AST_ONE_LAST: assert property (@(posedge clk) disable iff (rst) $onehot0(tx_valid & tx_last)); // R4

  for (genvar j = 1; j < NLANES; j++) begin : g_hold
    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rx_valid[j] && !rx_ready[j]) |=> (rx_valid[j] && $stable(rx_data[j*W +: W]))); // R3
  end
endmodule

bind xvp_ring_xfer xvp_ring_xfer_chk #(.NLANES(NLANES), .W(W), .QDEPTH(QDEPTH)) u_chk (.*);

// File: tb/xvp_ring_xfer_bench.sv
module xvp_ring_xfer_bench;
  localparam int NL = 4;
  localparam int W  = 16;
  localparam int QD = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NL-1:0]     tx_valid = '0, tx_last = '0, tx_ready;
  logic [NL*W-1:0]   tx_data = '0;
  logic [NL-1:0]     rx_valid, rx_ready = '0;
  logic [NL*W-1:0]   rx_data;
  logic              rx_first = 1'b0;
  logic              cp_push_valid = 1'b0, cp_push_ready;
  logic [W-1:0]      cp_push_data = '0, cp_pop_data;
  logic              cp_pop_valid, cp_pop_ready = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xvp_ring_xfer #(.NLANES(NL), .W(W), .QDEPTH(QD)) u_xvp_ring_xfer (.*);

  // {last, src lane[3:0], data[15:0]}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 4'd0, 16'h1A01}, {1'b0, 4'd1, 16'h2B02},
    {1'b0, 4'd2, 16'h3C03}, {1'b0, 4'd3, 16'h4D04},
    {1'b1, 4'd3, 16'h5E05}, {1'b1, 4'd1, 16'h6F06},
    {1'b0, 4'd2, 16'h7007}, {1'b1, 4'd0, 16'h8108}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cp_push(input logic [W-1:0] d);
    cp_push_valid = 1'b1; cp_push_data = d;
    step();
    cp_push_valid = 1'b0;
  endtask

  task automatic cp_pop_chk(input logic [W-1:0] exp, input string req);
    #1;
    chk(cp_pop_valid == 1'b1, req, {31'b0, cp_pop_valid}, 32'd1);
    chk(cp_pop_data == exp, req, {16'b0, cp_pop_data}, {16'b0, exp});
    cp_pop_ready = 1'b1;
    step();
    cp_pop_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 during reset
    chk(rx_valid == '0, "R1", {28'b0, rx_valid}, 0);
    chk(cp_pop_valid == 1'b0, "R1", {31'b0, cp_pop_valid}, 0);
    rst = 1'b0;
    step();
    chk(cp_push_ready == 1'b1, "R1", {31'b0, cp_push_ready}, 1);
    chk(tx_ready == '1, "R1", {28'b0, tx_ready}, 32'hF);
    chk(rx_valid == '0, "R1", {28'b0, rx_valid}, 0);

    // Table walk: R2, R4, R9
    for (int e = 0; e < 8; e++) begin
      automatic bit          last = VEC[e][20];
      automatic int          src  = int'(VEC[e][19:16]);
      automatic logic [W-1:0] d   = VEC[e][15:0];
      automatic int          dst  = last ? 0 : (src + 1) % NL;
      automatic string       req  = last ? "R4" : (dst == 0 ? "R9" : "R2");
      tx_valid[src] = 1'b1; tx_last[src] = last; tx_data[src*W +: W] = d;
      step();
      tx_valid = '0; tx_last = '0;
      rx_first = last;
      #1;
      chk(rx_valid[dst] == 1'b1, req, {31'b0, rx_valid[dst]}, 1);
      chk(rx_data[dst*W +: W] == d, req, {16'b0, rx_data[dst*W +: W]}, {16'b0, d});
      rx_ready[dst] = 1'b1;
      step();
      rx_ready = '0; rx_first = 1'b0;
      #1;
      chk(rx_valid[dst] == 1'b0, req, {31'b0, rx_valid[dst]}, 0);
    end

    // R3: link back-pressure and same-cycle refill
    @(negedge clk);
    tx_valid[1] = 1'b1; tx_data[1*W +: W] = 16'h1111;
    step();
    tx_data[1*W +: W] = 16'h2222;
    #1;
    chk(tx_ready[1] == 1'b0, "R3", {31'b0, tx_ready[1]}, 0);
    step();
    chk(rx_data[2*W +: W] == 16'h1111, "R3", {16'b0, rx_data[2*W +: W]}, 32'h1111);
    rx_ready[2] = 1'b1;
    #1;
    chk(tx_ready[1] == 1'b1, "R3", {31'b0, tx_ready[1]}, 1);
    step();
    tx_valid = '0; rx_ready = '0;
    #1;
    chk(rx_valid[2] && rx_data[2*W +: W] == 16'h2222, "R3", {15'b0, rx_valid[2], rx_data[2*W +: W]}, 32'h12222);
    rx_ready[2] = 1'b1;
    step();
    rx_ready = '0;

    // R4: FIFO order of two last-flagged sends from different lanes
    tx_valid[3] = 1'b1; tx_last[3] = 1'b1; tx_data[3*W +: W] = 16'hAAA1;
    step();
    tx_valid = '0; tx_last = '0;
    tx_valid[1] = 1'b1; tx_last[1] = 1'b1; tx_data[1*W +: W] = 16'hAAA2;
    step();
    tx_valid = '0; tx_last = '0;
    rx_first = 1'b1; rx_ready[0] = 1'b1;
    #1;
    chk(rx_data[W-1:0] == 16'hAAA1, "R4", {16'b0, rx_data[W-1:0]}, 32'hAAA1);
    step();
    chk(rx_data[W-1:0] == 16'hAAA2, "R4", {16'b0, rx_data[W-1:0]}, 32'hAAA2);
    step();
    rx_ready = '0; rx_first = 1'b0;

    // R5, R6: fill, refuse, drain in order, empty
    for (int i = 0; i < QD; i++) cp_push(16'h00A0 + 16'(i));
    #1;
    chk(cp_push_ready == 1'b0, "R6", {31'b0, cp_push_ready}, 0);
    cp_push(16'h00EE);
    for (int i = 0; i < QD; i++) cp_pop_chk(16'h00A0 + 16'(i), "R5");
    #1;
    chk(cp_pop_valid == 1'b0, "R6", {31'b0, cp_pop_valid}, 0);

    // R7: VP send and CP push collide
    @(negedge clk);
    tx_valid[2] = 1'b1; tx_last[2] = 1'b1; tx_data[2*W +: W] = 16'h7777;
    cp_push_valid = 1'b1; cp_push_data = 16'h5555;
    #1;
    chk(cp_push_ready == 1'b0, "R7", {31'b0, cp_push_ready}, 0);
    step();
    tx_valid = '0; tx_last = '0;
    step();
    cp_push_valid = 1'b0;
    cp_pop_chk(16'h7777, "R7");
    cp_pop_chk(16'h5555, "R7");

    // R8: lane 0 owns the head while rx_first is high
    cp_push(16'h8888);
    rx_first = 1'b1;
    #1;
    chk(cp_pop_valid == 1'b0, "R8", {31'b0, cp_pop_valid}, 0);
    chk(rx_valid[0] && rx_data[W-1:0] == 16'h8888, "R8", {15'b0, rx_valid[0], rx_data[W-1:0]}, 32'h18888);
    rx_ready[0] = 1'b1;
    step();
    rx_ready = '0; rx_first = 1'b0;
    #1;
    chk(cp_pop_valid == 1'b0, "R8", {31'b0, cp_pop_valid}, 0);

    // R10: push and pop on the same edge
    @(negedge clk);
    cp_push(16'h0010);
    cp_push(16'h0011);
    cp_push_valid = 1'b1; cp_push_data = 16'h0012;
    cp_pop_chk(16'h0010, "R10");
    cp_push_valid = 1'b0;
    cp_pop_chk(16'h0011, "R10");
    cp_pop_chk(16'h0012, "R10");
    #1;
    chk(cp_pop_valid == 1'b0, "R10", {31'b0, cp_pop_valid}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule